// File: doc/BRIEF.md
# Serial PHY Management Frame Engine

This block runs the two-wire management link to an Ethernet PHY: a management clock output (MDC) and a bidirectional data line (MDIO). Software places a complete frame in one 32-bit register write. The engine then sends 32 preamble ones, followed by all 32 register bits, most significant bit first. The start, operation and turnaround codes come from the word exactly as written, so the engine does not generate them itself. When the operation field holds the read code, the engine releases the data line at the turnaround bits. It samples the PHY's 16 reply bits and shifts them into the low half of the same register.

MDC is the system clock divided by 8, 16, 32 or 64. A 2-bit select input chooses the ratio, and software picks a larger ratio for a faster system clock. A management-port enable input gates the whole engine. An idle output tells software when the register holds a finished result.

Top module: `mdio_frame_engine`

## Requirements
- R1: The MDC period is 8, 16, 32 or 64 system clocks when `clk_sel` is 0, 1, 2 or 3. MDC is low for half the period and high for the other half.
- R2: A frame accepted while idle is sent as 32 ones followed by bits 31 down to 0 of the written word. Each bit is presented for one MDC period.
- R3: While enabled, `mdio_o` changes only in the cycle in which MDC falls. The value is therefore stable at the MDC rising edge, where the PHY samples it.
- R4: During any frame whose bits 29:28 are not 2'b10, `mdio_oe` stays high for all 64 bits. During a read (bits 29:28 = 2'b10), `mdio_oe` drops at the first turnaround bit (word bit 17, overall bit 46) and stays low to the end. `mdio_oe` is low whenever the engine is idle.
- R5: For a read, the engine samples `mdio_i` at MDC rising edges during the last 16 bit periods, first bit to bit 15. These bits replace `man_word[15:0]`, and `man_word[31:16]` keep their written value.
- R6: `idle` goes low in the cycle after a frame is accepted. It returns high at the MDC falling edge that ends the 64th bit.
- R7: A write arriving while a frame is in progress is ignored. The register and the frame in flight are unchanged.
- R8: While `mgmt_en` is low, writes are ignored, MDC is held low and `idle` is high. Clearing `mgmt_en` during a frame abandons it on the next clock and releases MDIO.
- R9: After reset, `idle` is high, MDC is low, `mdio_oe` is low and `man_word` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_en | input | 1 | Management port enable |
| clk_sel | input | 2 | MDC divide select (0:÷8, 1:÷16, 2:÷32, 3:÷64) |
| wr_en | input | 1 | Write strobe for the management register |
| wr_data | input | 32 | Frame word: start 31:30, op 29:28, PHY addr 27:23, reg addr 22:18, turnaround 17:16, data 15:0 |
| man_word | output | 32 | Current management register contents |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
An accepted write shows up in `idle` one clock later. The first preamble bit appears on `mdio_o` in the cycle the first following MDC fall is registered. Each captured read bit is in `man_word` one clock after the MDC rise that sampled it. `idle` returns in the cycle of the MDC fall after the 64th bit.

A behavioural model in the bench advances one step on each rising clock edge with the same stimulus. It is compared with every output at the following falling edge, so each of these latencies is checked in its own cycle. Directed checks sit on top of the model. A PHY responder captures the bit stream and the enable at each MDC rise, the MDC period is measured for each select value, and the final register word is compared after reads, ignored writes and aborts.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_W  = 32;
    localparam int PRE_W    = 32;
    localparam int TOTAL    = PRE_W + FRAME_W;
    localparam int IDX_W    = $clog2(TOTAL);
    localparam int POS_W    = $clog2(FRAME_W);
    localparam int DIV_W    = 6;
    localparam int HALF_MIN = 4;
    // overall bit index of first turnaround bit (word bit 17) and first data bit (word bit 15)
    localparam int TA_POS   = PRE_W + (FRAME_W - 1 - 17);
    localparam int DATA_POS = PRE_W + (FRAME_W - 1 - 15);
    localparam logic [1:0] OP_READ = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
    import mdio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       mdc,
    output logic       rise_stb,
    output logic       fall_stb
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t d, q;
    logic [DIV_W-1:0] lim;
    logic             tick;

    always_comb begin
        lim      = (DIV_W'(HALF_MIN) << sel) - DIV_W'(1);
        tick     = en && (q.cnt >= lim);
        d.cnt    = tick ? '0 : q.cnt + DIV_W'(1);
        d.mdc    = q.mdc ^ tick;
        if (!en) begin
            d = '0;
        end
        rise_stb = tick && !q.mdc;
        fall_stb = tick && q.mdc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.mdc;

    // R1
    mdc_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.mdc) |=> q.mdc);

    // R8
    mdc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !q.mdc);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_i,
    output logic [FRAME_W-1:0] man,
    output logic               busy,
    output logic               mdio_o,
    output logic               mdio_oe
);
    typedef struct packed {
        eng_state_e         state;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] man;
        logic               out;
        logic               oe;
    } sh_t;

    sh_t d, q;
    logic             is_read;
    logic [IDX_W-1:0] nxt;
    logic [POS_W-1:0] pos;

    always_comb begin
        d       = q;
        is_read = (q.man[29:28] == OP_READ);
        nxt     = q.idx + IDX_W'(1);
        pos     = ~nxt[POS_W-1:0];
        case (q.state)
            ST_IDLE: begin
                if (en && wr_en) begin
                    d.man   = wr_data;
                    d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (fall_stb) begin
                    d.state = ST_RUN;
                    d.idx   = '0;
                    d.out   = 1'b1;
                    d.oe    = 1'b1;
                end
            end
            ST_RUN: begin
                if (rise_stb && is_read && (q.idx >= IDX_W'(DATA_POS))) begin
                    d.man[15:0] = {q.man[14:0], mdio_i};
                end
                if (fall_stb) begin
                    if (q.idx == IDX_W'(TOTAL - 1)) begin
                        d.state = ST_IDLE;
                        d.oe    = 1'b0;
                    end else begin
                        d.idx = nxt;
                        d.out = (nxt < IDX_W'(PRE_W)) ? 1'b1 : q.man[pos];
                        d.oe  = !(is_read && (nxt >= IDX_W'(TA_POS)));
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (!en) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
            d.out   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.out   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign man     = q.man;
    assign busy    = (q.state != ST_IDLE);
    assign mdio_o  = q.out;
    assign mdio_oe = q.oe;

    // R7
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> (q.man[31:16] == $past(q.man[31:16])));

    // R6
    start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && en));

    // R4
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !q.oe);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mgmt_en,
    input  logic [1:0]  clk_sel,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] man_word,
    output logic        idle,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic rise_stb, fall_stb, busy;

    mdio_clk_div i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mgmt_en),
        .sel      (clk_sel),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_shifter i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mgmt_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .man      (man_word),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    assign idle = !busy;

    // R3
    out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_en && $past(mgmt_en) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));
endmodule

// File: tb/test_mdio_frame_engine.sv
module test_mdio_frame_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        mgmt_en = 0;
    logic [1:0]  clk_sel = 0;
    logic        wr_en = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] man_word;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1;

    mdio_frame_engine i_mdio_frame_engine (
        .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .clk_sel(clk_sel),
        .wr_en(wr_en), .wr_data(wr_data), .man_word(man_word), .idle(idle),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int       m_cnt, m_st, m_n, m_half;
    bit       m_mdc, m_out, m_oe, m_tk, m_rs, m_fl, m_rd;
    bit [31:0] m_man;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mdc = 0; m_st = 0; m_n = 0; m_man = 0; m_out = 1; m_oe = 0;
        end else if (!mgmt_en) begin
            m_cnt = 0; m_mdc = 0; m_st = 0; m_oe = 0; m_out = 1;
        end else begin
            m_half = 4 << clk_sel;
            m_tk = (m_cnt >= m_half - 1);
            m_rs = m_tk && !m_mdc;
            m_fl = m_tk && m_mdc;
            m_cnt = m_tk ? 0 : m_cnt + 1;
            if (m_tk) m_mdc = !m_mdc;
            m_rd = (m_man[29:28] == 2'b10);
            if (m_st == 0) begin
                if (wr_en) begin m_man = wr_data; m_st = 1; end
            end else if (m_st == 1) begin
                if (m_fl) begin m_st = 2; m_n = 0; m_out = 1; m_oe = 1; end
            end else begin
                if (m_rs && m_rd && m_n >= 48) m_man[15:0] = {m_man[14:0], mdio_i};
                if (m_fl) begin
                    if (m_n == 63) begin m_st = 0; m_oe = 0; end
                    else begin
                        m_n++;
                        m_out = (m_n < 32) ? 1'b1 : m_man[63 - m_n];
                        m_oe = !(m_rd && m_n >= 46);
                    end
                end
            end
        end
    end

    bit prev_o = 1, prev_mdc = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1", "mdc", mdc, m_mdc);
            check("R2", "mdio_o", mdio_o, m_out);
            check("R4", "mdio_oe", mdio_oe, m_oe);
            check("R6", "idle", idle, m_st == 0);
            check("R5", "man_word", man_word, m_man);
            if (mgmt_en && mdio_o != prev_o)
                check("R3", "mdio_o change without mdc fall", {prev_mdc, mdc}, 2'b10);
        end
        prev_o = mdio_o;
        prev_mdc = mdc;
    end

    // ---------------- PHY responder / frame capture ----------------
    bit        armed = 0, started = 0;
    int        rc = 0;
    bit [63:0] cap_bits, cap_oe;
    bit [15:0] phy_val = 16'h0;
    always @(negedge mdc) if (armed && !idle) started = 1;
    always @(posedge mdc) begin
        if (started && rc < 64) begin
            cap_bits[63 - rc] = mdio_o;
            cap_oe[63 - rc]   = mdio_oe;
            rc++;
            mdio_i = (rc >= 48 && rc <= 63) ? phy_val[63 - rc] : 1'b1;
        end
    end

    task automatic do_write(input bit [31:0] w);
        @(negedge clk); wr_en = 1; wr_data = w;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && !idle; i++) @(negedge clk);
    endtask

    task automatic run_frame(input bit [31:0] w);
        rc = 0; started = 0; armed = 0;
        do_write(w);
        armed = 1;
        check("R6", "idle low after accept", idle, 0);
        wait_idle();
        armed = 0;
        check("R6", "idle high at end", idle, 1);
    endtask

    task automatic measure(input bit [1:0] s);
        int t0;
        int t1;
        @(negedge clk); clk_sel = s;
        @(posedge mdc); @(posedge mdc); t0 = cyc;
        @(posedge mdc); t1 = cyc;
        check("R1", "mdc period", t1 - t0, 8 << s);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        bit [31:0] w;
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9", "idle", idle, 1);
        check("R9", "mdc", mdc, 0);
        check("R9", "mdio_oe", mdio_oe, 0);
        check("R9", "man_word", man_word, 0);
        rst_n = 1;
        @(negedge clk);

        // R8: disabled port ignores writes, mdc held low
        do_write(32'h5A5A_1234);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (i % 10 == 0) begin
                check("R8", "idle while disabled", idle, 1);
                check("R8", "mdc while disabled", mdc, 0);
            end
        end
        check("R8", "man_word unchanged", man_word, 0);

        mgmt_en = 1;
        // R1 divide ratios
        for (int s = 0; s < 4; s++) measure(2'(s));

        // R2 / R4 write frame at ÷8
        @(negedge clk); clk_sel = 0;
        w = {2'b01, 2'b01, 5'd3, 5'd9, 2'b10, 16'hBEEF};
        run_frame(w);
        check("R2", "write frame bits", cap_bits, {32'hFFFF_FFFF, w});
        check("R4", "write frame oe", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R4", "oe idle", mdio_oe, 0);

        // R5 / R4 read frame at ÷16, with busy write (R7)
        clk_sel = 1;
        phy_val = 16'hC3A5;
        w = {2'b01, 2'b10, 5'd1, 5'd2, 2'b10, 16'h0000};
        rc = 0; started = 0; armed = 0;
        do_write(w);
        armed = 1;
        repeat (200) @(negedge clk);
        do_write(32'h1111_2222);  // R7 ignored
        check("R7", "busy write ignored", man_word[31:16], w[31:16]);
        wait_idle();
        armed = 0;
        check("R5", "read result", man_word, {w[31:16], 16'hC3A5});
        check("R4", "read oe pattern", cap_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
        check("R2", "read header bits", cap_bits[63:18], {32'hFFFF_FFFF, w[31:18]});

        // second read, ÷64, different data
        clk_sel = 3;
        phy_val = 16'h0F01;
        w = {2'b01, 2'b10, 5'd31, 5'd0, 2'b10, 16'hFFFF};
        run_frame(w);
        check("R5", "read result 2", man_word, {w[31:16], 16'h0F01});

        // write with random-ish pattern at ÷32
        clk_sel = 2;
        w = 32'h5C3B_A965;
        run_frame(w);
        check("R2", "pattern frame bits", cap_bits, {32'hFFFF_FFFF, w});

        // R8 abort mid-frame
        clk_sel = 0;
        do_write({2'b01, 2'b10, 5'd4, 5'd4, 2'b10, 16'h0});
        repeat (300) @(negedge clk);
        check("R8", "busy before abort", idle, 0);
        mgmt_en = 0;
        @(negedge clk);
        check("R8", "idle after abort", idle, 1);
        check("R8", "oe after abort", mdio_oe, 0);
        check("R8", "mdc after abort", mdc, 0);
        @(negedge clk); mgmt_en = 1;
        w = 32'h5000_0001;
        run_frame(w);
        check("R2", "frame after abort", cap_bits, {32'hFFFF_FFFF, w});

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule